// File: doc/BRIEF.md
# Raw Black Level, Digital Gain and Test Pattern Stage

This stage sits at the head of a raw image pipeline and handles a stream of 10-bit samples. Each sample has a valid flag and frame-start and line-start markers. The stage first removes a programmable black offset, so that sensor black becomes code zero. Results that would go negative are held at zero. The offset-free value is then scaled by a digital gain between 1x and 8x. An exposure controller supplies this gain and may change it at any time. The stage applies a new gain only from the next frame start, so a frame never mixes two gains.

A register-selected test pattern can replace the gained stream. The choices are a solid level, a horizontal ramp and vertical bars, all driven by a pixel counter that restarts on every line. A final, separate stage adds a programmable level back in with saturation. This level should normally be left at zero. Every output appears exactly two cycles after its input, with valid and markers kept aligned to the data.

Top module: `raw_level_gain`

## Requirements
- R1: While reset is asserted, out_valid, out_sof, out_sol and out_data are all zero.
- R2: The stage computes in_data minus black_lvl, and any result below zero becomes 0.
- R3: gain_req is an unsigned value with 3 integer bits and 5 fraction bits (32 = 1x). The gained value is floor(diff*gain/32), saturated at 1023.
- R4: A gain_req below 32 is applied as 32 (1x). The gain in force after reset is 1x.
- R5: gain_req is sampled only on a valid beat with in_sof high. That beat and all later beats use the sampled value until the next such beat.
- R6: tp_sel picks the output source. 0 passes the gained value, 1 gives tp_value, 2 gives the pixel index modulo 1024, and 3 gives min(index/BAR_W,7)*146.
- R7: The pixel index is 0 on a valid beat that has in_sof or in_sol high. Otherwise it is one more than the index of the previous valid beat.
- R8: post_lvl is added after the source select, and the sum saturates at 1023.
- R9: Outputs appear two cycles after their input beat. out_valid, out_sof and out_sol copy in_valid, in_sof and in_sol from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | First sample of a frame |
| in_sol | input | 1 | First sample of a line |
| in_data | input | 10 | Raw input sample |
| black_lvl | input | 10 | Black offset to subtract |
| gain_req | input | 8 | Requested gain, 3.5 fixed point |
| tp_sel | input | 2 | Source select: 0 data, 1 solid, 2 ramp, 3 bars |
| tp_value | input | 10 | Solid pattern level |
| post_lvl | input | 10 | Level added after the source select |
| out_valid | output | 1 | Output sample valid |
| out_sof | output | 1 | Frame start, aligned to out_data |
| out_sol | output | 1 | Line start, aligned to out_data |
| out_data | output | 10 | Output sample |

## Verification
The bench builds the stage with 10-bit data, an 8-bit gain and a bar width of 4. With that bar width, lines of a few dozen pixels reach every bar, including the clamp at the last bar. The gain width lets the bench request 255, so 7.97x gain drives large samples into the 1023 ceiling. It also lets the bench request values below 32 to show the 1x floor. The bench changes the gain in the middle of a frame to check that the change waits for the next frame start.

// File: rtl/raw_level_gain.sv
module raw_level_gain #(
  parameter int DW    = 10,
  parameter int GW    = 8,
  parameter int FRAC  = 5,
  parameter int CW    = 12,
  parameter int BAR_W = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] black_lvl,
  input  logic [GW-1:0] gain_req,
  input  logic [1:0]    tp_sel,
  input  logic [DW-1:0] tp_value,
  input  logic [DW-1:0] post_lvl,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_sol,
  output logic [DW-1:0] out_data
);
  localparam logic [GW-1:0] ONE_X  = GW'(1 << FRAC);
  localparam logic [DW-1:0] MAXV   = {DW{1'b1}};
  localparam int            PW     = DW + GW;
  localparam int            STEP   = (2**DW - 1) / 7;

  logic [GW-1:0] gain_act, gain_lim, gain_eff;
  logic [CW-1:0] x_cnt, x_cur;
  logic [DW-1:0] diff;
  logic          take;

  logic          s1_v, s1_sof, s1_sol;
  logic [DW-1:0] s1_diff;
  logic [GW-1:0] s1_gain;
  logic [CW-1:0] s1_x;

  assign take     = in_valid && in_sof;
  assign gain_lim = (gain_req < ONE_X) ? ONE_X : gain_req;
  assign gain_eff = take ? gain_lim : gain_act;
  assign diff     = (in_data > black_lvl) ? in_data - black_lvl : '0;
  assign x_cur    = (in_sof || in_sol) ? '0 : x_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_act <= ONE_X;
      x_cnt    <= '0;
      s1_v     <= 1'b0;
      s1_sof   <= 1'b0;
      s1_sol   <= 1'b0;
      s1_diff  <= '0;
      s1_gain  <= ONE_X;
      s1_x     <= '0;
    end else begin
      if (take) gain_act <= gain_lim;
      if (in_valid) x_cnt <= x_cur;
      s1_v    <= in_valid;
      s1_sof  <= in_valid && in_sof;
      s1_sol  <= in_valid && in_sol;
      s1_diff <= diff;
      s1_gain <= gain_eff;
      s1_x    <= x_cur;
    end
  end

  logic [PW-1:0]   prod, scaled;
  logic [DW-1:0]   gained, ramp, bars, pat;
  logic [CW-1:0]   bar_raw;
  logic [2:0]      bar_idx;
  logic [DW:0]     sum;
  logic [DW-1:0]   final_v;

  assign prod    = PW'(s1_diff) * PW'(s1_gain);
  assign scaled  = prod >> FRAC;
  assign gained  = (scaled > PW'(MAXV)) ? MAXV : scaled[DW-1:0];
  assign ramp    = s1_x[DW-1:0];
  assign bar_raw = s1_x / CW'(BAR_W);
  assign bar_idx = (bar_raw > CW'(7)) ? 3'd7 : bar_raw[2:0];
  assign bars    = DW'(bar_idx) * DW'(STEP);

  always_comb begin
    case (tp_sel)
      2'd1:    pat = tp_value;
      2'd2:    pat = ramp;
      2'd3:    pat = bars;
      default: pat = gained;
    endcase
  end

  assign sum     = {1'b0, pat} + {1'b0, post_lvl};
  assign final_v = sum[DW] ? MAXV : sum[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_v;
      out_sof   <= s1_sof;
      out_sol   <= s1_sol;
      out_data  <= final_v;
    end
  end
endmodule

// File: rtl/raw_level_gain_chk.sv
module raw_level_gain_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic [DW-1:0] in_data,
  input logic [DW-1:0] black_lvl,
  input logic [1:0]    tp_sel,
  input logic [DW-1:0] tp_value,
  input logic [DW-1:0] post_lvl,
  input logic          out_valid,
  input logic          out_sof,
  input logic [DW-1:0] out_data
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  // R9
  latency_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  // R9
  latency_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_sof == ($past(in_valid, 2) && $past(in_sof, 2))));

  // R2
  black_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && $past(tp_sel) == 2'd0 && $past(post_lvl) == '0
     && $past(in_data, 2) <= $past(black_lvl, 2)) |-> (out_data == '0));

  // R3
  gain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && $past(tp_sel) == 2'd0 && $past(post_lvl) == '0
     && $past(in_data, 2) > $past(black_lvl, 2))
    |-> (out_data >= $past(in_data, 2) - $past(black_lvl, 2)));

  // R6
  solid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid && $past(tp_sel) == 2'd1 && $past(post_lvl) == '0)
    |-> (out_data == $past(tp_value)));

  // R8
  post_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> (out_data >= $past(post_lvl)));
endmodule

bind raw_level_gain raw_level_gain_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_data(in_data), .black_lvl(black_lvl), .tp_sel(tp_sel),
  .tp_value(tp_value), .post_lvl(post_lvl), .out_valid(out_valid),
  .out_sof(out_sof), .out_data(out_data)
);

// File: tb/tb_raw_level_gain.sv
module tb_raw_level_gain;
  localparam int BAR_W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 0, in_sof = 0, in_sol = 0;
  logic [9:0] in_data = '0, black_lvl = '0, tp_value = '0, post_lvl = '0;
  logic [7:0] gain_req = 8'd32;
  logic [1:0] tp_sel = '0;
  logic       out_valid, out_sof, out_sol;
  logic [9:0] out_data;

  raw_level_gain #(.DW(10), .GW(8), .FRAC(5), .CW(12), .BAR_W(BAR_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_sol(in_sol), .in_data(in_data), .black_lvl(black_lvl),
    .gain_req(gain_req), .tp_sel(tp_sel), .tp_value(tp_value),
    .post_lvl(post_lvl), .out_valid(out_valid), .out_sof(out_sof),
    .out_sol(out_sol), .out_data(out_data));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  int gact = 32, xc = 0;
  bit e1_v = 0, e1_f = 0, e1_l = 0, e2_v = 0, e2_f = 0, e2_l = 0;
  int e1_d = 0, e2_d = 0;

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int model(input bit v, input bit f, input bit l, input int d);
    int x, diff, g, p, s;
    if (v && f) gact = (gain_req < 32) ? 32 : int'(gain_req);
    x = (f || l) ? 0 : xc + 1;
    if (v) xc = x;
    diff = (d > int'(black_lvl)) ? d - int'(black_lvl) : 0;
    g = diff * gact / 32;
    if (g > 1023) g = 1023;
    case (tp_sel)
      2'd1: p = int'(tp_value);
      2'd2: p = x % 1024;
      2'd3: p = ((x / BAR_W) > 7 ? 7 : x / BAR_W) * 146;
      default: p = g;
    endcase
    s = p + int'(post_lvl);
    return (s > 1023) ? 1023 : s;
  endfunction

  task automatic step(input bit v, input bit f, input bit l, input int d);
    int nd;
    @(negedge clk);
    chk({tag, " R9 valid"}, int'(out_valid), int'(e2_v));
    if (e2_v) begin
      chk({tag, " R9 sof"}, int'(out_sof), int'(e2_f));
      chk({tag, " R9 sol"}, int'(out_sol), int'(e2_l));
      chk({tag, " data"}, int'(out_data), e2_d);
    end
    nd = model(v, f, l, d);
    e2_v = e1_v; e2_f = e1_f; e2_l = e1_l; e2_d = e1_d;
    e1_v = v; e1_f = v && f; e1_l = v && l; e1_d = nd;
    in_valid = v; in_sof = f; in_sol = l; in_data = 10'(d);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
  endtask

  task automatic line(input bit first, input int n, input int base, input int inc);
    for (int i = 0; i < n; i++) step(1, first && i == 0, i == 0, base + i * inc);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_sof", int'(out_sof), 0);
    chk("R1 out_sol", int'(out_sol), 0);
    chk("R1 out_data", int'(out_data), 0);
    rst_n = 1'b1;

    tag = "R2"; black_lvl = 10'd64; gain_req = 8'd32;
    line(1, 8, 0, 20);
    line(0, 6, 60, 3);
    flush();

    tag = "R3"; gain_req = 8'd64;
    line(1, 6, 100, 150);
    tag = "R5"; gain_req = 8'd255;
    line(0, 6, 200, 10);
    tag = "R3";
    line(1, 8, 100, 120);
    flush();

    tag = "R4"; black_lvl = 10'd0; gain_req = 8'd8;
    line(1, 5, 300, 7);
    gain_req = 8'd0;
    line(1, 5, 500, 1);
    flush();

    tag = "R6"; tp_sel = 2'd1; tp_value = 10'd777;
    line(1, 5, 10, 1);
    flush();
    tag = "R7"; tp_sel = 2'd2;
    line(1, 20, 0, 1);
    line(0, 12, 0, 1);
    flush();
    tag = "R6"; tp_sel = 2'd3;
    line(1, 40, 0, 1);
    flush();

    tag = "R8"; tp_sel = 2'd0; gain_req = 8'd32; post_lvl = 10'd100;
    line(1, 6, 0, 150);
    flush();
    post_lvl = 10'd1000; tp_sel = 2'd1; tp_value = 10'd50;
    line(1, 4, 0, 1);
    flush();

    tag = "R9"; tp_sel = 2'd0; post_lvl = 10'd0;
    for (int i = 0; i < 12; i++) step(i % 3 != 1, i == 0, i == 0 || i == 6, i * 40);
    flush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule